// File: doc/BRIEF.md
# Boot Mode Selector with Vector Page Remap

This block decides, each time reset is released, whether the processor core starts in user mode or in a debug-monitor mode. It then supplies the high byte of the address used for reset and software-interrupt vector fetches. User mode uses page 0xFF, and monitor mode uses page 0xFE, which points the core at monitor firmware instead of application code. It also drives the watchdog enable, because the watchdog must stay quiet while the monitor is in control.

Monitor mode is entered in one of two ways. The first is a high-voltage detect flag on the interrupt pin that is present during reset. The second is an erased reset vector. While in user mode, the block snoops the two reset-vector byte fetches. If both bytes read 0xFF, it latches a forced-monitor flag and requests an internal reset. That flag survives every later reset except power-on. In either monitor mode, the block counts eight security bytes from the serial receiver. It then asks the serial transmitter, once, to send a break.

Top module: `boot_mode_ctrl`

## Requirements
- R1: `vec_hi` is 0xFF in user mode and 0xFE in either monitor mode.
- R2: `hv_det` is sampled on every clock edge while `rst_n` is low. If it was 1 at the last such edge, the block leaves reset in monitor mode with `mode_stat` = 2'b01. Otherwise, unless forced, it leaves reset in user mode with `mode_stat` = 2'b00.
- R3: Once `rst_n` is high, the high-voltage mode decision does not change, whatever `hv_det` does.
- R4: In user mode, suppose a high-byte fetch (`vec_fetch`=1, `vec_lo`=0) reads 0xFF and the next low-byte fetch (`vec_fetch`=1, `vec_lo`=1) also reads 0xFF. Then `int_rst_req` is high for exactly one cycle, starting the cycle after the low-byte fetch, and `mode_stat` becomes 2'b11. If either byte differs from 0xFF, nothing happens.
- R5: The forced-monitor state (`mode_stat` = 2'b11) persists across `rst_n` resets. Only `por_n` low clears it.
- R6: `wdog_en` has three cases:
  - In user mode it is 1.
  - In forced monitor mode it is 0.
  - In high-voltage monitor mode it is 0 while `hv_det` is 1, and it follows `hv_det` going low without delay.
- R7: Receiver strobes (`rx_stb`) are counted only in monitor mode. The count returns to zero on every reset.
- R8: The eighth counted strobe makes `brk_req` high for one cycle, in the cycle after that strobe. No further break request is made until the next reset.
- R9: In either monitor mode, vector fetches reading 0xFF cause no internal reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears forced mode |
| rst_n | input | 1 | Any reset, active low, synchronous |
| hv_det | input | 1 | High voltage detected on the interrupt pin |
| vec_fetch | input | 1 | Core is reading a reset-vector byte this cycle |
| vec_lo | input | 1 | 0 = high vector byte, 1 = low vector byte |
| vec_data | input | 8 | Snooped data of the vector fetch |
| rx_stb | input | 1 | One received serial byte |
| vec_hi | output | 8 | Vector address high byte (page) |
| wdog_en | output | 1 | Watchdog enable |
| int_rst_req | output | 1 | Internal reset request pulse |
| brk_req | output | 1 | Request to send a break |
| mode_stat | output | 2 | bit0 = monitor mode, bit1 = forced by erased vector |

## Verification
The assertions rely on the following input behaviour:
- `por_n` is only asserted together with `rst_n`.
- A low-byte vector fetch is directly preceded by its high-byte fetch.
- `rx_stb` is a single-cycle pulse.

The stimulus meets these conditions:
- Every reset holds `rst_n` low for several cycles.
- Vector bytes are presented on consecutive cycles, high byte first.
- Strobes are separated by idle cycles.

`hv_det` changes only when a scenario intends to test its sampling or its live effect on the watchdog.

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl #(
  parameter int         SEC_BYTES = 8,
  parameter logic [7:0] USER_PAGE = 8'hFF,
  parameter logic [7:0] MON_PAGE  = 8'hFE,
  parameter logic [7:0] ERASED    = 8'hFF
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       hv_det,
  input  logic       vec_fetch,
  input  logic       vec_lo,
  input  logic [7:0] vec_data,
  input  logic       rx_stb,
  output logic [7:0] vec_hi,
  output logic       wdog_en,
  output logic       int_rst_req,
  output logic       brk_req,
  output logic [1:0] mode_stat
);
  localparam int CW = $clog2(SEC_BYTES + 1);

  logic          forced_q, hv_mode_q, hi_erased_q;
  logic [CW-1:0] cnt_q;
  logic          monitor, erase_hit, count_en;

  assign monitor   = forced_q | hv_mode_q;
  assign erase_hit = !monitor && vec_fetch && vec_lo && hi_erased_q && (vec_data == ERASED);
  assign count_en  = monitor && rx_stb && (cnt_q != CW'(SEC_BYTES));

  assign vec_hi    = monitor ? MON_PAGE : USER_PAGE;
  assign wdog_en   = !monitor || (!forced_q && !hv_det);
  assign mode_stat = {forced_q, monitor};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)         forced_q <= 1'b0;
    else if (erase_hit) forced_q <= 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv_mode_q   <= hv_det;
      hi_erased_q <= 1'b0;
      int_rst_req <= 1'b0;
      brk_req     <= 1'b0;
      cnt_q       <= '0;
    end else begin
      if (vec_fetch && !vec_lo) hi_erased_q <= (vec_data == ERASED);
      else if (vec_fetch)       hi_erased_q <= 1'b0;
      int_rst_req <= erase_hit;
      brk_req     <= count_en && (cnt_q == CW'(SEC_BYTES - 1));
      if (count_en) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> $stable(hv_mode_q)); // R3
  AST_FORCED_STICKY: assert property (@(posedge clk) disable iff (!por_n) forced_q |=> forced_q); // R5
  AST_ERASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    int_rst_req |-> $past(vec_fetch && vec_lo && vec_data == ERASED && !monitor)); // R4
  AST_MON_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $past(monitor) && monitor |-> !int_rst_req); // R9
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(SEC_BYTES)); // R7
  AST_USER_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n || !por_n) !monitor |=> $stable(cnt_q)); // R7
  AST_BRK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) brk_req |=> !brk_req); // R8
  AST_BRK_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) brk_req |-> cnt_q == CW'(SEC_BYTES)); // R8
endmodule

// File: tb/sim_boot_mode_ctrl.sv
module sim_boot_mode_ctrl;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, hv_det = 1'b0;
  logic vec_fetch = 1'b0, vec_lo = 1'b0, rx_stb = 1'b0;
  logic [7:0] vec_data = 8'h00;
  logic [7:0] vec_hi;
  logic wdog_en, int_rst_req, brk_req;
  logic [1:0] mode_stat;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  boot_mode_ctrl u0 (.clk, .por_n, .rst_n, .hv_det, .vec_fetch, .vec_lo, .vec_data,
                     .rx_stb, .vec_hi, .wdog_en, .int_rst_req, .brk_req, .mode_stat);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pwr, input logic hv);
    @(negedge clk);
    hv_det = hv; rst_n = 1'b0; if (pwr) por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fetch(input logic [7:0] hi, input logic [7:0] lo);
    vec_fetch = 1'b1; vec_lo = 1'b0; vec_data = hi;
    @(negedge clk);
    vec_lo = 1'b1; vec_data = lo;
    @(negedge clk);
    vec_fetch = 1'b0; vec_lo = 1'b0; vec_data = 8'h00;
  endtask

  task automatic strobe(output logic brk_seen);
    rx_stb = 1'b1;
    @(negedge clk);
    rx_stb = 1'b0;
    brk_seen = brk_req;
    @(negedge clk);
  endtask

  task automatic t_user_reset;
    do_reset(1'b1, 1'b0);
    chk("R2 user mode_stat", mode_stat, 2'b00);
    chk("R1 user page", vec_hi, 8'hFF);
    chk("R6 user wdog", wdog_en, 1'b1);
    chk("R4 no irq at reset", int_rst_req, 1'b0);
    chk("R8 no brk at reset", brk_req, 1'b0);
  endtask

  task automatic t_hv_monitor;
    logic b;
    do_reset(1'b1, 1'b1);
    chk("R2 hv mode_stat", mode_stat, 2'b01);
    chk("R1 monitor page", vec_hi, 8'hFE);
    chk("R6 hv wdog off", wdog_en, 1'b0);
    hv_det = 1'b0; #1;
    chk("R6 hv removed wdog on", wdog_en, 1'b1);
    @(negedge clk);
    chk("R3 mode held after hv drop", mode_stat, 2'b01);
    for (int i = 1; i <= 9; i++) begin
      strobe(b);
      if (i == 8) chk("R8 brk after 8th byte", b, 1'b1);
      else        chk("R8 no brk other byte", b, 1'b0);
    end
    chk("R8 brk single cycle", brk_req, 1'b0);
    fetch(8'hFF, 8'hFF);
    chk("R9 hv monitor ignores erased", int_rst_req, 1'b0);
    chk("R9 mode kept", mode_stat, 2'b01);
  endtask

  task automatic t_user_no_count;
    logic b;
    do_reset(1'b1, 1'b0);
    hv_det = 1'b1;
    @(negedge clk);
    chk("R3 late hv ignored", mode_stat, 2'b00);
    hv_det = 1'b0;
    for (int i = 0; i < 10; i++) begin
      strobe(b);
      chk("R7 user no count", b, 1'b0);
    end
  endtask

  task automatic t_partial_erase;
    do_reset(1'b1, 1'b0);
    fetch(8'hFF, 8'h40);
    chk("R4 low not erased irq", int_rst_req, 1'b0);
    fetch(8'h12, 8'hFF);
    chk("R4 high not erased irq", int_rst_req, 1'b0);
    chk("R4 still user", mode_stat, 2'b00);
  endtask

  task automatic t_erase_and_sticky;
    logic b;
    do_reset(1'b1, 1'b0);
    fetch(8'hFF, 8'hFF);
    chk("R4 erased irq", int_rst_req, 1'b1);
    chk("R4 forced mode_stat", mode_stat, 2'b11);
    chk("R1 forced page", vec_hi, 8'hFE);
    chk("R6 forced wdog off", wdog_en, 1'b0);
    @(negedge clk);
    chk("R4 irq one cycle", int_rst_req, 1'b0);
    do_reset(1'b0, 1'b0);
    chk("R5 forced kept over reset", mode_stat, 2'b11);
    chk("R6 forced wdog off hv low", wdog_en, 1'b0);
    fetch(8'hFF, 8'hFF);
    chk("R9 forced ignores erased", int_rst_req, 1'b0);
    for (int i = 1; i <= 8; i++) begin
      strobe(b);
      if (i == 8) chk("R7 forced counts, brk", b, 1'b1);
    end
    do_reset(1'b0, 1'b0);
    for (int i = 1; i <= 8; i++) begin
      strobe(b);
      if (i == 7) chk("R7 count cleared by reset", b, 1'b0);
      if (i == 8) chk("R8 brk again after reset", b, 1'b1);
    end
    do_reset(1'b1, 1'b0);
    chk("R5 power-on clears forced", mode_stat, 2'b00);
    chk("R1 page back to user", vec_hi, 8'hFF);
  endtask

  initial begin
    t_user_reset();
    t_hv_monitor();
    t_user_no_count();
    t_partial_erase();
    t_erase_and_sticky();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule